// File: doc/BRIEF.md
# Delayed Read Capture Unit

This unit sits on the initiator side of a bus bridge and acts as the target for memory reads. Reads are handled as delayed transactions. On the first attempt of a read, the unit takes the address, the command and the address parity from the address phase. It takes the byte enables in the first cycle where the initiator shows it is ready. It stores all of these as one request for the far side of the bridge and ends the attempt with a target retry. The initiator keeps repeating the same read. While the far side has not produced the data, each repeat is retried again.

When the data is available, the unit serves the repeat. Data is available when the far-side read has completed, its words are at the head of the read data queue, and the posted-write ordering logic gives permission. The unit then streams one word per ready cycle and signals a disconnect with the last word. After that word the request is retired and the unit can take a new read. It holds one outstanding request. A configuration input lets the three memory read commands count as equal when a repeat is compared against the stored request.

Top module: `dlyrd_target`

## Requirements
- R1: After reset, devsel_o, trdy_o, stop_o, req_pending_o, req_push_o and rdq_pop_o are all 0.
- R2: Only the memory read commands are claimed: cbe_i of 4'b0110 (read), 4'b1110 (read line) or 4'b1100 (read multiple) in the address phase (frame_i high, irdy_i low). Any other command leaves devsel_o, trdy_o and stop_o at 0 for the whole transaction.
- R3: With no request pending, a claimed read stores three values from the address phase: ad_i as the address, cbe_i as the command and par_i as the parity. It also stores cbe_i from the first cycle with irdy_i high as the byte enables. On the clock edge of that cycle, req_pending_o rises and req_push_o is high for exactly one cycle. The stored values appear on req_addr_o, req_cmd_o, req_par_o and req_be_o.
- R4: The attempt that stores a request is ended with a retry: devsel_o and stop_o are high and trdy_o is low until the initiator drops frame_i.
- R5: A repeat that matches the stored request is retried, with no data popped and the request kept, if any of these inputs is low: cpl_done_i, rdq_valid_i or order_ok_i.
- R6: While a request is pending, a read with a different address is retried without being stored: req_push_o stays 0 and the req_* fields keep their values.
- R7: With alias_en_i low, a repeat matches only if its command equals the stored one. With alias_en_i high, any of the three memory read commands matches any other.
- R8: A matching repeat with data ready gets trdy_o high whenever rdq_valid_i is high. ad_o carries rdq_data_i, and rdq_pop_o is high exactly in cycles with both trdy_o and irdy_i high. A cycle with irdy_i low pops nothing.
- R9: stop_o is high together with trdy_o on the word flagged by rdq_last_i, and on no earlier word.
- R10: When the last word is taken, dtq_retire_o pulses for that cycle and req_pending_o is 0 afterwards. The next new read is then stored as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alias_en_i | input | 1 | Treat all memory read commands as equal when matching |
| frame_i | input | 1 | Transaction in progress (active high) |
| irdy_i | input | 1 | Initiator ready (active high) |
| ad_i | input | 32 | Address from the initiator |
| cbe_i | input | 4 | Command in the address phase, byte enables afterwards |
| par_i | input | 1 | Address parity |
| devsel_o | output | 1 | Transaction claimed |
| trdy_o | output | 1 | Target ready, a data word is on ad_o |
| stop_o | output | 1 | Retry (without trdy_o) or disconnect (with trdy_o) |
| ad_o | output | 32 | Read data to the initiator |
| req_push_o | output | 1 | One-cycle pulse: a new request was stored |
| req_pending_o | output | 1 | A delayed request is outstanding |
| req_addr_o | output | 32 | Stored address |
| req_cmd_o | output | 4 | Stored command |
| req_be_o | output | 4 | Stored first-phase byte enables |
| req_par_o | output | 1 | Stored address parity |
| cpl_done_i | input | 1 | Far-side read for the request has completed |
| order_ok_i | input | 1 | Posted-write ordering allows the data to be returned |
| rdq_valid_i | input | 1 | Read data queue head holds a word |
| rdq_data_i | input | 32 | Read data queue head word |
| rdq_last_i | input | 1 | Head word is the last of the request |
| rdq_pop_o | output | 1 | Head word consumed this cycle |
| dtq_retire_o | output | 1 | Request retired this cycle |

## Verification
The hardest point to reach is a repeated read that matches the stored request in every field but still has to be retried. This happens when exactly one of the three readiness inputs is low while the other two are high. The bench stores a request first and then raises completion, queue data and ordering permission together. For each repeat it drops only one of them, and after every retry it checks that nothing was popped and the request is unchanged. The alias case is reached in the same way: the stored request is a plain read, a read-line repeat is made with aliasing off while data is fully ready, and then a read-multiple repeat is made with aliasing on.

// File: rtl/dlyrd_pkg.sv
// Package: shared constants, command codes and FSM state type for the
// delayed read capture unit. Assumes 4-bit command/byte-enable lanes.
package dlyrd_pkg;
    localparam int CBE_W = 4;

    localparam logic [CBE_W-1:0] CMD_MRD  = 4'b0110;
    localparam logic [CBE_W-1:0] CMD_MRDL = 4'b1110;
    localparam logic [CBE_W-1:0] CMD_MRDM = 4'b1100;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_CLAIM,
        TS_XFER,
        TS_HOLD,
        TS_SKIP
    } tgt_state_e;

    // True for any of the three memory read commands.
    function automatic logic is_mem_read(input logic [CBE_W-1:0] c);
        return (c == CMD_MRD) || (c == CMD_MRDL) || (c == CMD_MRDM);
    endfunction
endpackage

// File: rtl/dlyrd_cmd_match.sv
// Command comparator: decides whether a repeated command equals the stored
// one. With ALIAS_SUPPORT set and alias_en_i high, all memory read commands
// are treated as one. Assumes both commands are already known to be reads
// when aliasing applies; purely combinational.
module dlyrd_cmd_match
    import dlyrd_pkg::*;
#(
    parameter bit ALIAS_SUPPORT = 1'b1
) (
    input  logic [CBE_W-1:0] stored_cmd_i,
    input  logic [CBE_W-1:0] new_cmd_i,
    input  logic             alias_en_i,
    output logic             hit_o
);
    logic exact_hit;

    // Plain equality of the two command codes.
    always_comb exact_hit = (stored_cmd_i == new_cmd_i);

    generate
        if (ALIAS_SUPPORT) begin : g_alias
            // Equality, or both reads with aliasing enabled.
            always_comb hit_o = exact_hit ||
                (alias_en_i && is_mem_read(stored_cmd_i) && is_mem_read(new_cmd_i));
        end else begin : g_exact
            logic unused_alias;
            // Aliasing not built: only exact equality counts.
            always_comb unused_alias = alias_en_i;
            always_comb hit_o = exact_hit;
        end
    endgenerate
endmodule

// File: rtl/dlyrd_entry.sv
// Single delayed request holder: keeps address, command, byte enables and
// parity of one outstanding read. Loads only when empty (the caller must
// guarantee this), clears on retire. Pulses push_o one cycle after a load.
module dlyrd_entry
    import dlyrd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              retire_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CBE_W-1:0]  cmd_i,
    input  logic [CBE_W-1:0]  be_i,
    input  logic              par_i,
    output logic              valid_o,
    output logic              push_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CBE_W-1:0]  cmd_o,
    output logic [CBE_W-1:0]  be_o,
    output logic              par_o
);
    // Occupancy flag and push pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            push_o  <= 1'b0;
        end else begin
            push_o <= load_i;
            if (load_i)        valid_o <= 1'b1;
            else if (retire_i) valid_o <= 1'b0;
        end
    end

    // Request fields, captured on load only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_o <= '0;
            cmd_o  <= '0;
            be_o   <= '0;
            par_o  <= 1'b0;
        end else if (load_i) begin
            addr_o <= addr_i;
            cmd_o  <= cmd_i;
            be_o   <= be_i;
            par_o  <= par_i;
        end
    end
endmodule

// File: rtl/dlyrd_fsm.sv
// Target handshake sequencer. Detects the address phase (frame high, irdy
// low), claims memory reads, and at the first irdy cycle either stores a new
// request, serves data, or retries. Serves one word per irdy&rdq_valid cycle
// and disconnects with the last word. Assumes a well-behaved initiator that
// drops frame after a stop.
module dlyrd_fsm
    import dlyrd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              irdy_i,
    input  logic [ADDR_W-1:0] ad_i,
    input  logic [CBE_W-1:0]  cbe_i,
    input  logic              par_i,
    input  logic              ent_busy_i,
    input  logic              ent_hit_i,
    input  logic              data_ready_i,
    input  logic              rdq_valid_i,
    input  logic              rdq_last_i,
    output logic [ADDR_W-1:0] ph_addr_o,
    output logic [CBE_W-1:0]  ph_cmd_o,
    output logic              ph_par_o,
    output logic              capture_o,
    output logic              retire_o,
    output logic              devsel_o,
    output logic              trdy_o,
    output logic              stop_o,
    output logic              rdq_pop_o
);
    tgt_state_e st_q, st_d;
    logic       addr_phase;
    logic       beat;

    // Address phase and data beat qualifiers.
    always_comb begin
        addr_phase = (st_q == TS_IDLE) && frame_i && !irdy_i;
        beat       = (st_q == TS_XFER) && irdy_i && rdq_valid_i;
    end

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_IDLE:  if (addr_phase) st_d = is_mem_read(cbe_i) ? TS_CLAIM : TS_SKIP;
            TS_CLAIM: begin
                if (irdy_i) begin
                    if (!ent_busy_i)                    st_d = TS_HOLD;
                    else if (ent_hit_i && data_ready_i) st_d = TS_XFER;
                    else                                st_d = TS_HOLD;
                end else if (!frame_i) begin
                    st_d = TS_IDLE;
                end
            end
            TS_XFER: begin
                if (beat && rdq_last_i)  st_d = TS_HOLD;
                else if (beat && !frame_i) st_d = TS_IDLE;
            end
            TS_HOLD:  if (!frame_i) st_d = TS_IDLE;
            TS_SKIP:  if (!frame_i && !irdy_i) st_d = TS_IDLE;
            default:  st_d = TS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TS_IDLE;
        else        st_q <= st_d;
    end

    // Address-phase capture of address, command and parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_addr_o <= '0;
            ph_cmd_o  <= '0;
            ph_par_o  <= 1'b0;
        end else if (addr_phase) begin
            ph_addr_o <= ad_i;
            ph_cmd_o  <= cbe_i;
            ph_par_o  <= par_i;
        end
    end

    // Handshake and queue control outputs.
    always_comb begin
        capture_o = (st_q == TS_CLAIM) && irdy_i && !ent_busy_i;
        retire_o  = beat && rdq_last_i;
        rdq_pop_o = beat;
        devsel_o  = (st_q == TS_CLAIM) || (st_q == TS_XFER) || (st_q == TS_HOLD);
        trdy_o    = (st_q == TS_XFER) && rdq_valid_i;
        stop_o    = (st_q == TS_HOLD) || ((st_q == TS_XFER) && rdq_valid_i && rdq_last_i);
    end
endmodule

// File: rtl/dlyrd_target.sv
// Delayed read capture unit top. Ties the handshake sequencer, the single
// request holder and the command comparator together, qualifies data
// readiness from completion, queue head and ordering inputs, and muxes read
// data onto the bus. Assumes the read data queue presents words in order.
module dlyrd_target
    import dlyrd_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter bit ALIAS_SUPPORT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alias_en_i,
    input  logic              frame_i,
    input  logic              irdy_i,
    input  logic [ADDR_W-1:0] ad_i,
    input  logic [3:0]        cbe_i,
    input  logic              par_i,
    output logic              devsel_o,
    output logic              trdy_o,
    output logic              stop_o,
    output logic [ADDR_W-1:0] ad_o,
    output logic              req_push_o,
    output logic              req_pending_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [3:0]        req_cmd_o,
    output logic [3:0]        req_be_o,
    output logic              req_par_o,
    input  logic              cpl_done_i,
    input  logic              order_ok_i,
    input  logic              rdq_valid_i,
    input  logic [ADDR_W-1:0] rdq_data_i,
    input  logic              rdq_last_i,
    output logic              rdq_pop_o,
    output logic              dtq_retire_o
);
    logic [ADDR_W-1:0] ph_addr;
    logic [CBE_W-1:0]  ph_cmd;
    logic              ph_par;
    logic              capture;
    logic              cmd_hit;
    logic              ent_hit;
    logic              data_ready;

    // Match and readiness qualification for a repeated attempt.
    always_comb begin
        ent_hit    = req_pending_o && (req_addr_o == ph_addr) && cmd_hit;
        data_ready = cpl_done_i && rdq_valid_i && order_ok_i;
    end

    // Read data onto the bus only while target-ready.
    always_comb ad_o = trdy_o ? rdq_data_i : '0;

    dlyrd_cmd_match #(.ALIAS_SUPPORT(ALIAS_SUPPORT)) u_match (
        .stored_cmd_i (req_cmd_o),
        .new_cmd_i    (ph_cmd),
        .alias_en_i   (alias_en_i),
        .hit_o        (cmd_hit)
    );

    dlyrd_entry #(.ADDR_W(ADDR_W)) u_entry (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (capture),
        .retire_i (dtq_retire_o),
        .addr_i   (ph_addr),
        .cmd_i    (ph_cmd),
        .be_i     (cbe_i),
        .par_i    (ph_par),
        .valid_o  (req_pending_o),
        .push_o   (req_push_o),
        .addr_o   (req_addr_o),
        .cmd_o    (req_cmd_o),
        .be_o     (req_be_o),
        .par_o    (req_par_o)
    );

    dlyrd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_i      (frame_i),
        .irdy_i       (irdy_i),
        .ad_i         (ad_i),
        .cbe_i        (cbe_i),
        .par_i        (par_i),
        .ent_busy_i   (req_pending_o),
        .ent_hit_i    (ent_hit),
        .data_ready_i (data_ready),
        .rdq_valid_i  (rdq_valid_i),
        .rdq_last_i   (rdq_last_i),
        .ph_addr_o    (ph_addr),
        .ph_cmd_o     (ph_cmd),
        .ph_par_o     (ph_par),
        .capture_o    (capture),
        .retire_o     (dtq_retire_o),
        .devsel_o     (devsel_o),
        .trdy_o       (trdy_o),
        .stop_o       (stop_o),
        .rdq_pop_o    (rdq_pop_o)
    );
endmodule

// File: rtl/dlyrd_target_chk.sv
// Checker for the delayed read capture unit: port-level temporal properties,
// attached to every dlyrd_target instance by the bind below.
module dlyrd_target_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irdy_i,
    input logic              devsel_o,
    input logic              trdy_o,
    input logic              stop_o,
    input logic              req_push_o,
    input logic              req_pending_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic [3:0]        req_cmd_o,
    input logic              rdq_last_i,
    input logic              rdq_pop_o,
    input logic              dtq_retire_o
);
    // R3: a push marks a fresh request
    a_r3_push_new: assert property (@(posedge clk) disable iff (!rst_n)
        req_push_o |-> (req_pending_o && !$past(req_pending_o)));

    // R4: a retry or disconnect is always a claimed transaction
    a_r4_stop_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> devsel_o);

    // R6: the pending request fields never change while it stays pending
    a_r6_entry_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pending_o && $past(req_pending_o)) |-> ($stable(req_addr_o) && $stable(req_cmd_o)));

    // R8: a pop only happens on a completed data beat
    a_r8_pop_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rdq_pop_o |-> (trdy_o && irdy_i && devsel_o));

    // R9: a disconnect with data only on the last word
    a_r9_disc_last: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && trdy_o) |-> rdq_last_i);

    // R10: a retire frees the request
    a_r10_retire_free: assert property (@(posedge clk) disable iff (!rst_n)
        dtq_retire_o |=> !req_pending_o);
endmodule

bind dlyrd_target dlyrd_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irdy_i        (irdy_i),
    .devsel_o      (devsel_o),
    .trdy_o        (trdy_o),
    .stop_o        (stop_o),
    .req_push_o    (req_push_o),
    .req_pending_o (req_pending_o),
    .req_addr_o    (req_addr_o),
    .req_cmd_o     (req_cmd_o),
    .rdq_last_i    (rdq_last_i),
    .rdq_pop_o     (rdq_pop_o),
    .dtq_retire_o  (dtq_retire_o)
);

// File: tb/dlyrd_target_tb_top.sv
// Directed bench for the delayed read capture unit.
module dlyrd_target_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alias_en_i = 1'b0;
    logic        frame_i = 1'b0;
    logic        irdy_i = 1'b0;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        par_i = 1'b0;
    logic        devsel_o, trdy_o, stop_o;
    logic [31:0] ad_o;
    logic        req_push_o, req_pending_o, req_par_o;
    logic [31:0] req_addr_o;
    logic [3:0]  req_cmd_o, req_be_o;
    logic        cpl_done_i = 1'b0;
    logic        order_ok_i = 1'b0;
    logic        rdq_valid_i, rdq_last_i;
    logic [31:0] rdq_data_i;
    logic        rdq_pop_o, dtq_retire_o;

    // Read data queue model
    logic [31:0] rmem [4];
    int          rlen = 0;
    int          ridx = 0;
    logic        rdq_avail = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    assign rdq_valid_i = rdq_avail && (ridx < rlen);
    assign rdq_data_i  = (ridx < 4) ? rmem[ridx] : 32'h0;
    assign rdq_last_i  = (ridx == rlen - 1);

    always @(posedge clk) if (rdq_pop_o) ridx <= ridx + 1;

    dlyrd_target dut_i (
        .clk(clk), .rst_n(rst_n), .alias_en_i(alias_en_i),
        .frame_i(frame_i), .irdy_i(irdy_i), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
        .devsel_o(devsel_o), .trdy_o(trdy_o), .stop_o(stop_o), .ad_o(ad_o),
        .req_push_o(req_push_o), .req_pending_o(req_pending_o),
        .req_addr_o(req_addr_o), .req_cmd_o(req_cmd_o), .req_be_o(req_be_o),
        .req_par_o(req_par_o), .cpl_done_i(cpl_done_i), .order_ok_i(order_ok_i),
        .rdq_valid_i(rdq_valid_i), .rdq_data_i(rdq_data_i), .rdq_last_i(rdq_last_i),
        .rdq_pop_o(rdq_pop_o), .dtq_retire_o(dtq_retire_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Address phase then first irdy cycle; leaves state after the decision edge.
    task automatic start_read(input logic [31:0] a, input logic [3:0] c,
                              input logic [3:0] be, input logic p);
        frame_i = 1'b1; irdy_i = 1'b0; ad_i = a; cbe_i = c; par_i = p;
        tick();
        irdy_i = 1'b1; cbe_i = be; ad_i = 32'h0;
        tick();
    endtask

    // Release the bus after a stop.
    task automatic release_bus();
        frame_i = 1'b0;
        tick();
        irdy_i = 1'b0;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 devsel", {31'b0, devsel_o}, 32'd0);
        chk("R1 trdy/stop", {30'b0, trdy_o, stop_o}, 32'd0);
        chk("R1 pending/push", {30'b0, req_pending_o, req_push_o}, 32'd0);
        chk("R1 pop", {31'b0, rdq_pop_o}, 32'd0);
    endtask

    task automatic t_nonread();
        frame_i = 1'b1; ad_i = 32'h0000_4000; cbe_i = 4'b0111;
        tick();
        chk("R2 write not claimed", {31'b0, devsel_o}, 32'd0);
        irdy_i = 1'b1; cbe_i = 4'hF;
        tick();
        chk("R2 no response", {29'b0, devsel_o, trdy_o, stop_o}, 32'd0);
        chk("R2 nothing stored", {31'b0, req_pending_o}, 32'd0);
        release_bus();
    endtask

    task automatic t_first();
        frame_i = 1'b1; ad_i = 32'h1234_5670; cbe_i = 4'b0110; par_i = 1'b1;
        tick();
        chk("R2 read claimed", {31'b0, devsel_o}, 32'd1);
        par_i = 1'b0; ad_i = 32'h0;
        cbe_i = 4'b1010;          // byte enables shown before irdy: must not be taken
        tick();
        chk("R3 not stored before irdy", {31'b0, req_pending_o}, 32'd0);
        irdy_i = 1'b1; cbe_i = 4'b0011;
        tick();
        chk("R3 push pulse", {30'b0, req_push_o, req_pending_o}, 32'd3);
        chk("R3 addr", req_addr_o, 32'h1234_5670);
        chk("R3 cmd/be/par", {23'b0, req_cmd_o, req_be_o, req_par_o}, {23'b0, 4'b0110, 4'b0011, 1'b1});
        chk("R4 retry", {29'b0, devsel_o, trdy_o, stop_o}, 32'b101);
        cbe_i = 4'hF;
        tick();
        chk("R3 push one cycle", {31'b0, req_push_o}, 32'd0);
        chk("R4 retry held", {29'b0, devsel_o, trdy_o, stop_o}, 32'b101);
        release_bus();
        chk("R4 released", {29'b0, devsel_o, trdy_o, stop_o}, 32'd0);
    endtask

    task automatic t_other_addr();
        cpl_done_i = 1'b1; order_ok_i = 1'b1; rdq_avail = 1'b1;
        start_read(32'h0000_8000, 4'b0110, 4'b1111, 1'b0);
        chk("R6 retry other addr", {29'b0, devsel_o, trdy_o, stop_o}, 32'b101);
        chk("R6 no push", {31'b0, req_push_o}, 32'd0);
        chk("R6 entry kept", req_addr_o, 32'h1234_5670);
        chk("R6 be kept", {28'b0, req_be_o}, 32'b0011);
        release_bus();
    endtask

    task automatic t_alias_off();
        alias_en_i = 1'b0;
        start_read(32'h1234_5670, 4'b1110, 4'b0011, 1'b0);
        chk("R7 alias off retries", {29'b0, devsel_o, trdy_o, stop_o}, 32'b101);
        chk("R7 no pop", ridx, 32'd0);
        release_bus();
    endtask

    task automatic t_not_ready();
        for (int k = 0; k < 3; k++) begin
            cpl_done_i = (k != 0); rdq_avail = (k != 1); order_ok_i = (k != 2);
            start_read(32'h1234_5670, 4'b0110, 4'b0011, 1'b0);
            chk("R5 retry when not ready", {29'b0, devsel_o, trdy_o, stop_o}, 32'b101);
            chk("R5 entry kept", {31'b0, req_pending_o}, 32'd1);
            chk("R5 no pop", ridx, 32'd0);
            release_bus();
        end
        cpl_done_i = 1'b1; rdq_avail = 1'b1; order_ok_i = 1'b1;
    endtask

    task automatic t_complete();
        alias_en_i = 1'b1;
        start_read(32'h1234_5670, 4'b1100, 4'b0011, 1'b0);
        #1;
        chk("R7 alias on serves", {29'b0, devsel_o, trdy_o, stop_o}, 32'b110);
        chk("R8 word0", ad_o, 32'hA000_0000);
        chk("R8 pop on beat", {31'b0, rdq_pop_o}, 32'd1);
        tick();
        irdy_i = 1'b0;
        #1;
        chk("R8 wait no pop", {30'b0, rdq_pop_o, trdy_o}, 32'b01);
        chk("R9 no early stop", {31'b0, stop_o}, 32'd0);
        tick();
        irdy_i = 1'b1;
        #1;
        chk("R8 word1", ad_o, 32'hA000_0001);
        chk("R9 no stop mid", {31'b0, stop_o}, 32'd0);
        tick();
        chk("R8 word2", ad_o, 32'hA000_0002);
        chk("R9 disconnect with last", {30'b0, trdy_o, stop_o}, 32'b11);
        chk("R10 retire pulse", {31'b0, dtq_retire_o}, 32'd1);
        tick();
        chk("R10 freed", {31'b0, req_pending_o}, 32'd0);
        chk("R8 three pops", ridx, 32'd3);
        release_bus();
    endtask

    task automatic t_new_after();
        start_read(32'h0000_0C00, 4'b1110, 4'b1100, 1'b1);
        chk("R10 new stored", {30'b0, req_push_o, req_pending_o}, 32'd3);
        chk("R10 new addr", req_addr_o, 32'h0000_0C00);
        chk("R10 new cmd", {28'b0, req_cmd_o}, 32'b1110);
        release_bus();
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < 4; i++) rmem[i] = 32'hA000_0000 + i;
        rlen = 3;
        repeat (3) tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_nonread();
        t_first();
        t_other_addr();
        t_alias_off();
        t_not_ready();
        t_complete();
        t_new_after();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule